// File: doc/BRIEF.md
# Dual Parallel Port with Rise Assist

This block holds two bidirectional 8-bit parallel ports behind a small CPU register bus. Each port has an output value register and a direction register. A bit whose direction is set to output drives its output value on the pin. A bit whose direction is clear is released and can be read as an input. Pin levels pass through a two-stage synchronizer before they reach the read path.

Each port bit also has a rise-assist strobe. The strobe goes high for exactly one clock cycle when the level that bit drives changes from low to high. The pad driver can use it to add current for that one cycle and so speed up the rising edge. The level a bit drives is taken to be high only when the bit is an output and its output value is 1. So both of these count as a rise: writing a 1 into the value of an output bit, and switching a bit that already holds a 1 from input to output.

A static strap input sets what a read of a data register returns for bits that are outputs. With the strap low, those bits return the synchronized pin level. With the strap high, they return the stored output value, so that read-modify-write sequences stay correct when the pins settle slowly. Input bits always return the synchronized pin.

Top module: `port_assist_top`

## Requirements
- R1: While reset is asserted and after it is released, every output value bit, direction bit and assist strobe is 0, and a read of either direction register returns 0x00.
- R2: The register selector `bus_addr` decodes as follows: 0 is the port A data register, 1 is the port B data register, 2 is the port A direction register, 3 is the port B direction register. A write with `bus_wr` high takes effect at that clock edge and changes only the selected register.
- R3: `pa_out`/`pb_out` show the stored output values, and `pa_oe`/`pb_oe` show the direction registers, where bit value 1 means output. A read of a direction register returns its stored value.
- R4: A data register bit whose direction is input reads back the pin level sampled two clock edges earlier, whatever the strap level.
- R5: With `cfg_rd_latch` low, a data register bit whose direction is output reads back the synchronized pin level.
- R6: With `cfg_rd_latch` high, a data register bit whose direction is output reads back its stored output value.
- R7: A bit's assist strobe is high for one cycle, starting in the cycle after the write edge, when a write changes that output bit's value from 0 to 1.
- R8: An input bit never asserts its assist strobe, including when a 1 is written into its output value.
- R9: A direction change from input to output on a bit whose output value is 1 asserts that bit's assist strobe for one cycle.
- R10: The assist strobe never stays high for two cycles in a row, including when the same 1 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_latch | input | 1 | Static strap: 1 makes output bits read their stored value |
| bus_addr | input | 2 | Register selector |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pa_boost | output | 8 | Port A rise-assist strobes |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pb_boost | output | 8 | Port B rise-assist strobes |

## Verification
The hardest case to reach from the ports is a rise of the driven level that comes from the direction register rather than from the value register. To get there, the stimulus first writes a 1 into a bit's value while the bit is still an input, and checks that no strobe appears. It then writes the direction register and checks that the strobe is high for exactly one cycle. Repeated writes of the same 1 and a clear-then-set sequence show that a strobe follows only a true low-to-high change. Tests with mixed direction masks under both strap levels show how each bit chooses its read source.

// File: rtl/port_assist_pkg.sv
package port_assist_pkg;

    typedef enum logic [1:0] {
        SEL_DATA_A = 2'd0,
        SEL_DATA_B = 2'd1,
        SEL_DIR_A  = 2'd2,
        SEL_DIR_B  = 2'd3
    } reg_sel_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/port_sync.sv
module port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pin_raw;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.stage[STAGES-1];

    // R4
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stage[1] == $past(st_q.stage[0]));

endmodule

// File: rtl/port_lane.sv
module port_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_latch,
    input  logic         wr_val,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] val_out,
    output logic [W-1:0] dir_out,
    output logic [W-1:0] boost_out,
    output logic [W-1:0] data_rd
);

    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] dir;
        logic [W-1:0] boost;
    } lane_t;

    lane_t ln_d, ln_q;
    logic [W-1:0] drive_now, drive_next;

    always_comb begin
        ln_d = ln_q;
        if (wr_val) ln_d.val = wdata;
        if (wr_dir) ln_d.dir = wdata;
        drive_now   = ln_q.dir & ln_q.val;
        drive_next  = ln_d.dir & ln_d.val;
        ln_d.boost  = drive_next & ~drive_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_rd
            assign data_rd[b] = (ln_q.dir[b] && rd_latch) ? ln_q.val[b] : pin_sync[b];
        end
    endgenerate

    assign val_out   = ln_q.val;
    assign dir_out   = ln_q.dir;
    assign boost_out = ln_q.boost;

    // R8
    boost_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_out & ~dir_out) == '0);

    // R10
    boost_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_out & $past(boost_out)) == '0);

    // R7
    boost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_out == ((dir_out & val_out) & ~($past(dir_out) & $past(val_out))));

    // R6
    rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch |-> ((data_rd & dir_out) == (val_out & dir_out)));

endmodule

// File: rtl/port_assist_top.sv
module port_assist_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_rd_latch,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    output logic [W-1:0] pa_boost,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    output logic [W-1:0] pb_boost
);
    import port_assist_pkg::*;

    localparam int NP = NUM_PORTS;

    logic [NP-1:0][W-1:0] pin_raw, pin_syn, val_o, dir_o, bst_o, rd_o;
    logic [NP-1:0]        wr_val, wr_dir;
    reg_sel_e             sel;

    assign sel        = reg_sel_e'(bus_addr);
    assign pin_raw[0] = pa_in;
    assign pin_raw[1] = pb_in;

    always_comb begin
        wr_val = '0;
        wr_dir = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_DATA_A: wr_val[0] = 1'b1;
                SEL_DATA_B: wr_val[1] = 1'b1;
                SEL_DIR_A:  wr_dir[0] = 1'b1;
                SEL_DIR_B:  wr_dir[1] = 1'b1;
                default: ;
            endcase
        end
    end

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_port
            port_sync #(.W(W), .STAGES(2)) sync_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_raw  (pin_raw[p]),
                .pin_sync (pin_syn[p])
            );
            port_lane #(.W(W)) lane_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .rd_latch  (cfg_rd_latch),
                .wr_val    (wr_val[p]),
                .wr_dir    (wr_dir[p]),
                .wdata     (bus_wdata),
                .pin_sync  (pin_syn[p]),
                .val_out   (val_o[p]),
                .dir_out   (dir_o[p]),
                .boost_out (bst_o[p]),
                .data_rd   (rd_o[p])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_DATA_A: bus_rdata = rd_o[0];
            SEL_DATA_B: bus_rdata = rd_o[1];
            SEL_DIR_A:  bus_rdata = dir_o[0];
            SEL_DIR_B:  bus_rdata = dir_o[1];
            default:    bus_rdata = '0;
        endcase
    end

    assign pa_out   = val_o[0];
    assign pa_oe    = dir_o[0];
    assign pa_boost = bst_o[0];
    assign pb_out   = val_o[1];
    assign pb_oe    = dir_o[1];
    assign pb_boost = bst_o[1];

    // R2
    write_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> ($stable(pb_out) && $stable(pb_oe) && $stable(pa_oe)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (pa_out == '0 && pb_out == '0 && pa_oe == '0 && pb_oe == '0
                    && pa_boost == '0 && pb_boost == '0));

endmodule

// File: tb/port_assist_top_tb_top.sv
module port_assist_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rd_latch = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00, pa_out, pa_oe, pa_boost;
    logic [7:0] pb_in = 8'h00, pb_out, pb_oe, pb_boost;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    port_assist_top #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rd_latch(cfg_rd_latch),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_boost(pa_boost),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_boost(pb_boost)
    );

    // we, waddr, wdata, raddr, pa, pb, strap, expected read
    typedef struct packed {
        logic       we;
        logic [1:0] wa;
        logic [7:0] wd;
        logic [1:0] ra;
        logic [7:0] pa;
        logic [7:0] pb;
        logic       strap;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 8'h0F, 2'd0, 8'hA5, 8'h00, 1'b0, 8'hA5}, // R5 R4
        '{1'b1, 2'd0, 8'h33, 2'd0, 8'hA5, 8'h00, 1'b1, 8'hA3}, // R6 R4
        '{1'b0, 2'd0, 8'h00, 2'd0, 8'hA5, 8'h00, 1'b0, 8'hA5}, // R5
        '{1'b1, 2'd3, 8'hF0, 2'd3, 8'hA5, 8'h00, 1'b0, 8'hF0}, // R3
        '{1'b1, 2'd1, 8'h5A, 2'd1, 8'hA5, 8'h0F, 1'b1, 8'h5F}, // R6 R2
        '{1'b0, 2'd0, 8'h00, 2'd1, 8'hA5, 8'h0F, 1'b0, 8'h0F}, // R5
        '{1'b0, 2'd0, 8'h00, 2'd2, 8'hA5, 8'h0F, 1'b0, 8'h0F}, // R3
        '{1'b1, 2'd0, 8'hFF, 2'd0, 8'h00, 8'h0F, 1'b1, 8'h0F}  // R6 R4
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 during reset
        check("R1", pa_out | pb_out | pa_oe | pb_oe, 8'h00);
        check("R1", pa_boost | pb_boost, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_addr = 2'd2; #1 check("R1", bus_rdata, 8'h00);
        bus_addr = 2'd3; #1 check("R1", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pa_in = VEC[i].pa;
            pb_in = VEC[i].pb;
            cfg_rd_latch = VEC[i].strap;
            if (VEC[i].we) bus_write(VEC[i].wa, VEC[i].wd);
            else @(negedge clk);
            repeat (2) @(negedge clk);
            bus_addr = VEC[i].ra;
            #1 check($sformatf("R2/R4/R5/R6 vec %0d", i), bus_rdata, VEC[i].exp);
        end
        // R3 output pins after the table
        check("R3", pa_out, 8'hFF);
        check("R3", pa_oe, 8'h0F);
        check("R3", pb_out, 8'h5A);

        // R4 latency: two edges
        do_reset();
        cfg_rd_latch = 1'b1;
        bus_addr = 2'd0;
        pa_in = 8'h3C;
        @(negedge clk); #1 check("R4 one edge", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R4 two edges", bus_rdata, 8'h3C);

        // Assist strobes
        do_reset();
        bus_write(2'd0, 8'h81);
        check("R8", pa_boost, 8'h00);
        bus_write(2'd2, 8'h01);
        check("R9", pa_boost, 8'h01);
        @(negedge clk);
        check("R10", pa_boost, 8'h00);
        bus_write(2'd0, 8'h00);
        check("R7 fall", pa_boost, 8'h00);
        bus_write(2'd0, 8'h03);
        check("R7", pa_boost, 8'h01);
        bus_write(2'd0, 8'h03);
        check("R10 rewrite", pa_boost, 8'h00);
        bus_write(2'd3, 8'hFF);
        check("R8 B", pb_boost, 8'h00);
        bus_write(2'd1, 8'hAA);
        check("R7 B", pb_boost, 8'hAA);
        check("R2 A untouched", pa_out, 8'h03);
        @(negedge clk);
        check("R10 B", pb_boost, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule